// File: doc/BRIEF.md
# Store Queue with Youngest-Match Lookup

This block holds stores that have been issued but not yet written into the level-one data cache. Each accepted store becomes one entry made of an address and a data word. Entries are kept in arrival order. A drain port always presents the oldest entry, so the cache can retire stores in program order. When every entry is in use, the store input deasserts its ready signal and the producer stalls until an entry frees up.

A load probes this queue in the same cycle that it probes the cache. The lookup port compares the load's word address with every valid entry at once, and returns a hit flag together with the data. A hit here takes priority over the cache. Several pending stores can target the same word. In that case the lookup returns the data of the store that arrived last, so the load sees the newest value.

Depth must be a power of two of at least 2. The byte-offset bits of an address take no part in matching.

Top module: `store_queue_search`

## Requirements
- R1: After reset the queue is empty: `dr_valid` is 0, `st_ready` is 1 and `lk_hit` is 0 for any address.
- R2: A store is accepted on a clock edge where `st_valid` and `st_ready` are both 1, and the queue holds up to DEPTH (default 4) stores at the same time.
- R3: While DEPTH entries are held and `dr_ready` is 0, `st_ready` is 0. A store offered then is not taken, and it never appears at the lookup or drain ports.
- R4: `dr_valid` is 1 exactly when at least one entry is held. `dr_addr` and `dr_data` show the oldest entry, which leaves on an edge where `dr_valid` and `dr_ready` are both 1. Stores leave in the order they arrived.
- R5: When the queue is full and `dr_ready` is 1, `st_ready` is 1. A store and a drain on the same edge are both accepted, and the queue stays full.
- R6: `lk_hit` and `lk_data` respond combinationally to `lk_addr`. A hit means some held entry has the same address bits above the low OFS_W (default 2) byte-offset bits.
- R7: When more than one held entry matches, `lk_data` is the data of the most recently accepted of them.
- R8: The byte-offset bits of `lk_addr` and of the stored address do not affect matching.
- R9: A store being accepted on the coming edge is not visible to the lookup in that same cycle. It becomes visible after that edge.
- R10: Once an entry has drained, it no longer produces a lookup hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | A store is offered |
| st_ready | output | 1 | The queue can take the offered store |
| st_addr | input | ADDR_W | Byte address of the store |
| st_data | input | DATA_W | Store data word |
| dr_valid | output | 1 | The oldest entry is presented |
| dr_ready | input | 1 | The cache retires the presented entry |
| dr_addr | output | ADDR_W | Address of the oldest entry |
| dr_data | output | DATA_W | Data of the oldest entry |
| lk_addr | input | ADDR_W | Load byte address to search for |
| lk_hit | output | 1 | A held entry matches the load |
| lk_data | output | DATA_W | Data of the youngest matching entry |

## Verification
The assertions check four things on every cycle:
- the count of valid entries always equals the pointer distance;
- a refused store leaves the pointers and valid bits untouched;
- a stalled head keeps its address and data;
- a swap at full occupancy keeps the occupancy the same, and no lookup hits an empty queue.

Some behaviours depend on values and order rather than on counts, so only the bench scenarios can show them:
- the youngest of several matches wins;
- offset bits are ignored;
- a store accepted in the same cycle stays hidden from the lookup;
- drained stores stop matching;
- entries drain in arrival order.

// File: rtl/store_queue_search.sv
`timescale 1ns/1ps
module store_queue_search #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              dr_valid,
  input  logic              dr_ready,
  output logic [ADDR_W-1:0] dr_addr,
  output logic [DATA_W-1:0] dr_data,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic [PTR_W:0]    wr_ptr, rd_ptr, occ;
  logic [PTR_W-1:0]  wr_idx, rd_idx;
  logic              full, empty, do_enq, do_deq;
  logic [DEPTH-1:0]  hit_vec;
  logic              lk_ofs_unused;

  assign wr_idx   = wr_ptr[PTR_W-1:0];
  assign rd_idx   = rd_ptr[PTR_W-1:0];
  assign occ      = wr_ptr - rd_ptr;
  assign empty    = (wr_ptr == rd_ptr);
  assign full     = (wr_ptr[PTR_W] != rd_ptr[PTR_W]) && (wr_idx == rd_idx);
  assign dr_valid = !empty;
  assign st_ready = !full || dr_ready;
  assign do_enq   = st_valid && st_ready;
  assign do_deq   = dr_valid && dr_ready;
  assign dr_addr  = addr_q[rd_idx];
  assign dr_data  = data_q[rd_idx];
  assign lk_ofs_unused = ^lk_addr[OFS_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      vld_q  <= '0;
    end else begin
      if (do_deq) begin
        vld_q[rd_idx] <= 1'b0;
        rd_ptr        <= rd_ptr + 1'b1;
      end
      if (do_enq) begin
        vld_q[wr_idx] <= 1'b1;
        wr_ptr        <= wr_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_enq) begin
      addr_q[wr_idx] <= st_addr;
      data_q[wr_idx] <= st_data;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] &&
                        (addr_q[g][ADDR_W-1:OFS_W] == lk_addr[ADDR_W-1:OFS_W]);
  end

  always_comb begin
    logic [PTR_W-1:0] idx;
    lk_hit  = 1'b0;
    lk_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = rd_idx + PTR_W'(k);
      if (hit_vec[idx]) begin
        lk_hit  = 1'b1;
        lk_data = data_q[idx];
      end
    end
  end

  AST_VALID_EQ_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_q) == int'(occ)); // R2
  AST_REFUSED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> $stable(wr_ptr) && $stable(vld_q)); // R3
  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid && !dr_ready |=> dr_valid && $stable(dr_addr) && $stable(dr_data)); // R4
  AST_SWAP_KEEPS_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    do_enq && do_deq |=> occ == $past(occ)); // R5
  AST_NO_HIT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> dr_valid); // R6
endmodule

// File: tb/store_queue_search_tb.sv
`timescale 1ns/1ps
module store_queue_search_tb;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          st_valid = 1'b0, dr_ready = 1'b0;
  logic [AW-1:0] st_addr = '0, lk_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic          st_ready, dr_valid, lk_hit;
  logic [AW-1:0] dr_addr;
  logic [DW-1:0] dr_data, lk_data;

  typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } ent_t;
  ent_t exp_q[$];
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  store_queue_search #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(4), .OFS_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .dr_valid(dr_valid), .dr_ready(dr_ready),
    .dr_addr(dr_addr), .dr_data(dr_data), .lk_addr(lk_addr), .lk_hit(lk_hit),
    .lk_data(lk_data));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    ent_t e;
    if (rst_n && dr_valid && dr_ready) begin
      if (exp_q.size() == 0) chk("R4 unexpected drain", 64'(dr_data), 64'hDEAD);
      else begin
        e = exp_q.pop_front();
        chk("R4 drain order", {dr_addr, dr_data}, {e.a, e.d});
      end
    end
  end

  task automatic store(logic [AW-1:0] a, logic [DW-1:0] d);
    st_valid = 1'b1; st_addr = a; st_data = d;
    @(posedge clk);
    if (st_ready) exp_q.push_back('{a: a, d: d});
    #1 st_valid = 1'b0;
  endtask

  task automatic look(string req, logic [AW-1:0] a);
    logic h = 1'b0;
    logic [DW-1:0] v = '0;
    lk_addr = a;
    #1;
    foreach (exp_q[i])
      if (exp_q[i].a[AW-1:2] == a[AW-1:2]) begin h = 1'b1; v = exp_q[i].d; end
    chk({req, " hit"}, 64'(lk_hit), 64'(h));
    if (h) chk({req, " data"}, 64'(lk_data), 64'(v));
  endtask

  task automatic drain(int n);
    dr_ready = 1'b1;
    repeat (n) @(posedge clk);
    #1 dr_ready = 1'b0;
  endtask

  initial begin
    #100000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    chk("R1 dr_valid", 64'(dr_valid), 0);
    chk("R1 st_ready", 64'(st_ready), 1);
    lk_addr = 32'h100; #1;
    chk("R1 lk_hit", 64'(lk_hit), 0);

    store(32'h100, 32'h11);
    store(32'h200, 32'h22);
    store(32'h100, 32'h33);
    store(32'h300, 32'h44);
    #1;
    chk("R2 four accepted", 64'(exp_q.size()), 4);
    chk("R3 full stalls", 64'(st_ready), 0);
    chk("R4 nonempty valid", 64'(dr_valid), 1);

    look("R7 youngest of two", 32'h100);
    chk("R7 youngest value", 64'(lk_data), 64'h33);
    look("R8 offset ignored", 32'h103);
    chk("R8 offset value", 64'(lk_data), 64'h33);
    look("R6 single match", 32'h200);
    look("R6 other word miss", 32'h204);

    store(32'h500, 32'h55);
    chk("R3 refused store kept out", 64'(exp_q.size()), 4);
    look("R3 refused not visible", 32'h500);

    st_valid = 1'b1; st_addr = 32'h600; st_data = 32'h66; dr_ready = 1'b1;
    #1 chk("R5 ready while full with drain", 64'(st_ready), 1);
    @(posedge clk);
    if (st_ready) exp_q.push_back('{a: 32'h600, d: 32'h66});
    #1 st_valid = 1'b0; dr_ready = 1'b0;
    #1 chk("R5 still full", 64'(st_ready), 0);
    look("R5 new entry visible", 32'h600);

    look("R7 after oldest gone", 32'h100);
    drain(2);
    look("R10 drained no hit", 32'h100);
    chk("R10 drained hit flag", 64'(lk_hit), 0);

    st_valid = 1'b1; st_addr = 32'h700; st_data = 32'h77; lk_addr = 32'h700;
    #1 chk("R9 same-cycle store hidden", 64'(lk_hit), 0);
    @(posedge clk);
    if (st_ready) exp_q.push_back('{a: 32'h700, d: 32'h77});
    #1 st_valid = 1'b0;
    look("R9 visible after edge", 32'h700);
    chk("R9 value", 64'(lk_data), 64'h77);

    drain(4);
    #1;
    chk("R4 empty after drain", 64'(dr_valid), 0);
    chk("R4 all drained", 64'(exp_q.size()), 0);
    look("R10 empty lookup", 32'h700);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule